// File: doc/BRIEF.md
# Platform System Control Port Registers

This block is a byte-wide register bank on an ISA-style I/O bus. It decodes a 12-bit port address qualified by separate write and read strobes. Some of its ports hold state that drives chip-level lines: a soft-reset request, a hard-disk activity light and an I/O map-type select. Two ports return no data; writing either one fires a single-cycle toggle strobe towards a password-lock circuit. The rest are fixed identification values that firmware reads to learn the board's configuration.

A 4-bit system control field is kept masked to its width. The endian mode comes from a strap pin and appears, shifted, in the control port's read value. Read data is registered, so the value appears one clock after the read strobe and then holds until the next read. Any port address the bank does not claim reads as all ones, and writes to it are dropped.

Top module: `sysctl_regs`

## Requirements
- R1: A write to port 0x092 stores write-data bit 0, and the `soft_reset` output follows the stored bit from the cycle after the write edge.
- R2: A read of port 0x092 returns the `endian_strap` input in bit 1, with all other bits zero.
- R3: The identification ports are read-only and return fixed values: 0x810 returns 0xEF, 0x811 returns 0xAD, 0x812 returns 0xE0, 0x813 returns 0x39, and 0x817 returns 0x03 (no second-level cache).
- R4: A write to port 0x814 sets the `disk_light` output when write-data bit 0 is 1 and clears it when bit 0 is 0.
- R5: A write to port 0x815 raises `lock1_toggle`, and a write to port 0x816 raises `lock2_toggle`, each for exactly one cycle after the write edge. No other write raises either strobe.
- R6: A write to port 0x818 stores write-data bits 3:0. A read returns those bits in 3:0, with bits 7:4 zero.
- R7: A write to port 0x819 stores write-data bit 0. The stored bit drives `map_type` continuously and reads back in bit 0, with the other bits zero.
- R8: Reads of any other address, including the write-only ports 0x814 to 0x816, return 0xFF. Writes to those addresses and to the read-only ports leave every output and every readable value unchanged.
- R9: While `rst_n` is low, all stored bits, both strobes and `io_rdata` are zero.
- R10: `io_rdata` takes the value of the addressed port at the clock edge where `io_rd` is sampled high, and holds it on every edge where `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 12 | Port address |
| io_wr | input | 1 | Write strobe, sampled each rising edge |
| io_rd | input | 1 | Read strobe, sampled each rising edge |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| endian_strap | input | 1 | Endian mode strap |
| soft_reset | output | 1 | Soft-reset request |
| disk_light | output | 1 | Hard-disk light state |
| lock1_toggle | output | 1 | One-cycle toggle strobe for lock 1 |
| lock2_toggle | output | 1 | One-cycle toggle strobe for lock 2 |
| map_type | output | 1 | I/O map type select |

## Verification
A wrong stored bit shows on its dedicated output in the cycle after the write edge. For the control field, it shows on `io_rdata` one clock after the next read of that port. A decode fault is more subtle: an alias or a missing address either moves an output on a write that should be ignored, or returns a wrong byte on a read. For that reason the sweeps cover every one of the 4096 addresses, both reading each one and writing each one, and compare every side-effect output after every write. Strobe faults show up as a strobe that is missing in the cycle after the write, or one that is still high a cycle later.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int NUM_SLOTS = 11;
   localparam int DATA_W    = 8;
   // slot indices; slot 0 is the lone control port, slots 1.. sit in one bank
   localparam int SL_CTRL  = 0;
   localparam int SL_CPU   = 1;
   localparam int SL_FEAT  = 2;
   localparam int SL_STAT  = 3;
   localparam int SL_EXTF  = 4;
   localparam int SL_LIGHT = 5;
   localparam int SL_LOCK1 = 6;
   localparam int SL_LOCK2 = 7;
   localparam int SL_CACHE = 8;
   localparam int SL_SYSC  = 9;
   localparam int SL_MAP   = 10;
   typedef logic [NUM_SLOTS-1:0] slot_sel_t;
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h092,
   parameter logic [ADDR_W-1:0] BANK_BASE = 'h810
) (
   input  logic [ADDR_W-1:0] addr,
   output slot_sel_t         sel
);
   localparam int BANK_LAST = int'(BANK_BASE) + NUM_SLOTS - 2;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("sysctl_decode: ADDR_W too small");
      end
      if (BANK_LAST >= (1 << ADDR_W)) begin : g_bad_bank
         $error("sysctl_decode: register bank exceeds address space");
      end
      if (int'(CTRL_ADDR) >= int'(BANK_BASE) && int'(CTRL_ADDR) <= BANK_LAST) begin : g_overlap
         $error("sysctl_decode: control port overlaps register bank");
      end
   endgenerate

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      if (i == SL_CTRL) begin : g_ctrl
         assign sel[i] = (addr == CTRL_ADDR);
      end else begin : g_bank
         localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(int'(BANK_BASE) + i - 1);
         assign sel[i] = (addr == SLOT_A);
      end
   end

   always_comb begin
      if (!$isunknown(addr)) begin
         assert_decode_onehot_R8: assert ($onehot0(sel));
      end
   end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
   import sysctl_pkg::*;
#(
   parameter int SYSC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  slot_sel_t         sel,
   output logic              soft_reset,
   output logic              disk_light,
   output logic              lock1_toggle,
   output logic              lock2_toggle,
   output logic [SYSC_W-1:0] sysc,
   output logic              map_type
);
   generate
      if (SYSC_W < 1 || SYSC_W > DATA_W) begin : g_bad_sysc
         $error("sysctl_store: SYSC_W out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         soft_reset   <= 1'b0;
         disk_light   <= 1'b0;
         lock1_toggle <= 1'b0;
         lock2_toggle <= 1'b0;
         sysc         <= '0;
         map_type     <= 1'b0;
      end else begin
         lock1_toggle <= wr && sel[SL_LOCK1];
         lock2_toggle <= wr && sel[SL_LOCK2];
         if (wr && sel[SL_CTRL])  soft_reset <= wdata[0];
         if (wr && sel[SL_LIGHT]) disk_light <= wdata[0];
         if (wr && sel[SL_SYSC])  sysc       <= wdata[SYSC_W-1:0];
         if (wr && sel[SL_MAP])   map_type   <= wdata[0];
      end
   end

   assert_reset_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel[SL_CTRL]) |=> (soft_reset == $past(wdata[0])));
   assert_light_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(disk_light) |-> $past(wr && sel[SL_LIGHT]));
   assert_lock1_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock1_toggle |-> $past(wr && sel[SL_LOCK1]));
   assert_lock2_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock2_toggle |-> $past(wr && sel[SL_LOCK2]));
   assert_sysc_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel[SL_SYSC]) |=> (sysc == $past(wdata[SYSC_W-1:0])));
   assert_map_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(map_type) |-> $past(wr && sel[SL_MAP]));
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int SYSC_W = 4,
   parameter logic [DATA_W-1:0] CPU_ID   = 8'hEF,
   parameter logic [DATA_W-1:0] FEAT_ID  = 8'hAD,
   parameter logic [DATA_W-1:0] STAT_ID  = 8'hE0,
   parameter logic [DATA_W-1:0] EXTF_ID  = 8'h39,
   parameter logic [DATA_W-1:0] CACHE_ID = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  slot_sel_t         sel,
   input  logic              endian,
   input  logic [SYSC_W-1:0] sysc,
   input  logic              map_type,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = '1;
      if (sel[SL_CTRL])  rd_next = DATA_W'({endian, 1'b0});
      if (sel[SL_CPU])   rd_next = CPU_ID;
      if (sel[SL_FEAT])  rd_next = FEAT_ID;
      if (sel[SL_STAT])  rd_next = STAT_ID;
      if (sel[SL_EXTF])  rd_next = EXTF_ID;
      if (sel[SL_CACHE]) rd_next = CACHE_ID;
      if (sel[SL_SYSC])  rd_next = DATA_W'(sysc);
      if (sel[SL_MAP])   rd_next = DATA_W'(map_type);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (rd) rdata <= rd_next;
   end

   assert_unmapped_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && (sel == '0)) |=> (rdata == '1));
   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rdata));
   assert_ctrl_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel[SL_CTRL]) |=> (rdata == DATA_W'({$past(endian), 1'b0})));
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int SYSC_W = 4,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h092,
   parameter logic [ADDR_W-1:0] BANK_BASE = 'h810
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic              endian_strap,
   output logic              soft_reset,
   output logic              disk_light,
   output logic              lock1_toggle,
   output logic              lock2_toggle,
   output logic              map_type
);
   slot_sel_t         sel;
   logic [SYSC_W-1:0] sysc;

   sysctl_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .BANK_BASE(BANK_BASE)) u_decode (
      .addr (io_addr),
      .sel  (sel)
   );

   sysctl_store #(.SYSC_W(SYSC_W)) u_store (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr           (io_wr),
      .wdata        (io_wdata),
      .sel          (sel),
      .soft_reset   (soft_reset),
      .disk_light   (disk_light),
      .lock1_toggle (lock1_toggle),
      .lock2_toggle (lock2_toggle),
      .sysc         (sysc),
      .map_type     (map_type)
   );

   sysctl_rdmux #(.SYSC_W(SYSC_W)) u_rdmux (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd       (io_rd),
      .sel      (sel),
      .endian   (endian_strap),
      .sysc     (sysc),
      .map_type (map_type),
      .rdata    (io_rdata)
   );

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(lock1_toggle && lock2_toggle));
endmodule

// File: tb/sysctl_regs_tb.sv
module sysctl_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        endian_strap = 1'b0;
   logic        soft_reset, disk_light, lock1_toggle, lock2_toggle, map_type;

   int checks = 0;
   int errors = 0;

   // reference state
   logic       m_reset = 0, m_light = 0, m_map = 0;
   logic [3:0] m_sysc = 0;

   always #10 clk = ~clk;

   sysctl_regs u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .endian_strap(endian_strap),
      .soft_reset(soft_reset), .disk_light(disk_light), .lock1_toggle(lock1_toggle),
      .lock2_toggle(lock2_toggle), .map_type(map_type)
   );

   function automatic logic [7:0] exp_rd(input logic [11:0] a);
      case (a)
         12'h092: return {6'b0, endian_strap, 1'b0};
         12'h810: return 8'hEF;
         12'h811: return 8'hAD;
         12'h812: return 8'hE0;
         12'h813: return 8'h39;
         12'h817: return 8'h03;
         12'h818: return {4'b0, m_sysc};
         12'h819: return {7'b0, m_map};
         default: return 8'hFF;
      endcase
   endfunction

   function automatic string req_of(input logic [11:0] a);
      case (a)
         12'h092: return "R2";
         12'h810, 12'h811, 12'h812, 12'h813, 12'h817: return "R3";
         12'h818: return "R6";
         12'h819: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [11:0] a);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      chk(req_of(a), io_rdata, exp_rd(a));
   endtask

   task automatic do_write(input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (a == 12'h092) m_reset = d[0];
      if (a == 12'h814) m_light = d[0];
      if (a == 12'h818) m_sysc  = d[3:0];
      if (a == 12'h819) m_map   = d[0];
      chk("R1", {7'b0, soft_reset}, {7'b0, m_reset});
      chk("R4", {7'b0, disk_light}, {7'b0, m_light});
      chk("R7", {7'b0, map_type}, {7'b0, m_map});
      chk("R5", {6'b0, lock2_toggle, lock1_toggle}, {6'b0, a == 12'h816, a == 12'h815});
      @(negedge clk);
      chk("R5", {6'b0, lock2_toggle, lock1_toggle}, 8'h00);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9", {3'b0, soft_reset, disk_light, lock1_toggle, lock2_toggle, map_type}, 8'h00);
      chk("R9", io_rdata, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);

      // full read sweep from reset state, strap low
      for (int a = 0; a < 4096; a++) do_read(12'(a));

      // R6 / R7: every write value, masked readback
      for (int d = 0; d < 256; d++) begin
         do_write(12'h818, 8'(d));
         do_read(12'h818);
      end
      for (int d = 0; d < 256; d++) begin
         do_write(12'h819, 8'(d));
         do_read(12'h819);
      end
      // R1 / R4 toggling patterns
      for (int d = 0; d < 8; d++) begin
         do_write(12'h092, 8'(d * 37));
         do_write(12'h814, 8'(d * 53 + 1));
      end
      // R5: lock strobes, back to back
      do_write(12'h815, 8'h00);
      do_write(12'h816, 8'hFF);
      do_write(12'h815, 8'h5A);

      // R8: write every address, then check nothing unexpected moved
      do_write(12'h818, 8'h0A);
      for (int a = 0; a < 4096; a++) begin
         do_write(12'(a), 8'(a ^ (a >> 4) ^ 8'hA5));
      end
      endian_strap = 1'b1;
      for (int a = 0; a < 4096; a++) do_read(12'(a));

      // R10: hold while io_rd low, even with address moving
      do_read(12'h810);
      @(negedge clk); io_addr = 12'h819;
      @(negedge clk); io_addr = 12'h000;
      @(negedge clk);
      chk("R10", io_rdata, 8'hEF);
      do_read(12'h092);
      endian_strap = 1'b0;
      @(negedge clk);
      chk("R10", io_rdata, 8'h02);

      // R9: reset mid-run clears state
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9", {3'b0, soft_reset, disk_light, lock1_toggle, lock2_toggle, map_type}, 8'h00);
      chk("R9", io_rdata, 8'h00);
      rst_n = 1'b1;
      m_reset = 0; m_light = 0; m_map = 0; m_sysc = 0;
      do_read(12'h818);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule